// File: doc/BRIEF.md
# Serial Transmit Path with Holding Buffer

This block turns bytes written by a host into an asynchronous serial character stream. Each byte lands in a transmit holding store. With buffering enabled, that store is a 16-entry first-in first-out queue. With buffering disabled, it holds only one byte. A shift stage takes one byte at a time from the store and sends it on `txd` as a framed character. The line-control inputs set the word length, the parity and the stop-bit count.

Bit timing comes from a 16x oversampling tick. A 16-bit divisor sets the tick period in clock cycles, and the divisor is loaded as a high byte and a low byte. The divisor for a given rate is the clock frequency divided by sixteen times the rate. For example, a 14.7456 MHz clock with divisor 1 gives 921.6 kbaud, and with divisor 0x0900 it gives 400 baud. The block has two separate status flags: one for an empty holding store and one for an idle shifter. It also has an interrupt output that follows the holding-empty flag when the interrupt is enabled.

Top module: `uart_tx_core`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `txd` is 1, `thr_empty` is 1, `tsr_empty` is 1, the store is empty and the divisor is 0.
- R2: With a divisor D of at least 1, the 16x tick fires once every D clocks. With D = 0 no tick fires. A divisor write sets D to {`div_msb`,`div_lsb`} and restarts the tick count, so the next tick comes D clocks after the write.
- R3: Each serial bit, including start, parity and stop bits, stays on `txd` for exactly 16 ticks.
- R4: The line is 1 while idle. A character is a 0 start bit, then the data bits least-significant first, then an optional parity bit, then the stop bits, which are 1.
- R5: `word_len` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. `stop_two`=1 sends two stop bits and 0 sends one. The line-control inputs are sampled when a byte enters the shifter.
- R6: With `parity_en`=1, the parity bit makes the count of ones over the data bits and the parity bit even when `parity_odd`=0, and odd when `parity_odd`=1.
- R7: With `fifo_en`=1 the store holds up to 16 bytes and sends them in write order. A write while 16 bytes are held is dropped.
- R8: With `fifo_en`=0 the store holds one byte. A write while that byte is still held is dropped.
- R9: `thr_empty` goes to 0 in the clock after an accepted write. It returns to 1 in the clock after the last held byte moves into the shifter.
- R10: `tsr_empty` goes to 0 in the clock after an accepted write. It goes to 1 only in the clock after the final stop bit ends with nothing held and no write in that clock.
- R11: `tx_irq` is 1 exactly when `tx_int_en` is 1 and `thr_empty` is 1.
- R12: When the shifter is idle and a byte is held, the byte enters the shifter at the next clock and the start bit appears on `txd` in that same clock. One idle clock separates back-to-back characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_wr | input | 1 | Write strobe for the holding register |
| thr_data | input | 8 | Byte to send |
| div_wr | input | 1 | Divisor load strobe |
| div_msb | input | 8 | Divisor high byte |
| div_lsb | input | 8 | Divisor low byte |
| fifo_en | input | 1 | 1 selects 16-deep buffering, 0 a single holding byte |
| tx_int_en | input | 1 | Transmit-empty interrupt enable |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit enable |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| stop_two | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | Holding store empty |
| tsr_empty | output | 1 | Shifter idle with nothing queued |
| tx_irq | output | 1 | Transmit-empty interrupt |

## Verification
The assertions assume that `fifo_en` only changes while the store is empty. They also assume the divisor is non-zero whenever a character should finish. The stimulus changes the buffer mode and the line settings only after it has waited for the line to go fully idle. It uses a zero divisor only to stall a start bit, and loads a non-zero value before waiting for completion. Writes may arrive at any time, including against a full store, because that is the behaviour under test.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmit path.
// Assumes characters of at most 12 bits: 1 start, 8 data, 1 parity, 2 stop.
package uart_tx_pkg;
    localparam int FRAME_W = 12;
    localparam int LEN_W   = 4;

    typedef struct packed {
        logic [1:0] wlen;     // data bits minus five
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } line_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // bit 0 goes out first
        logic [LEN_W-1:0]   len;   // number of bit times in the character
    } frame_t;

    // Assemble a character: start, data bits LSB first, optional parity, stop ones.
    function automatic frame_t build_frame(input logic [7:0] d, input line_cfg_t c);
        frame_t f;
        int     nd;
        logic   p;
        nd        = 5 + int'(c.wlen);
        f.bits    = '1;
        f.bits[0] = 1'b0;
        p         = c.par_odd;
        for (int i = 0; i < 8; i++) begin
            if (i < nd) begin
                f.bits[1+i] = d[i];
                p           = p ^ d[i];
            end
        end
        if (c.par_en) f.bits[1+nd] = p;
        f.len = LEN_W'(1 + nd + (c.par_en ? 1 : 0) + (c.two_stop ? 2 : 1));
        return f;
    endfunction
endpackage

// File: rtl/uart_baud_gen.sv
// 16x tick generator. tick_o is high for one clock out of every div_q clocks.
// A divisor of zero holds the counter and gives no ticks. A divisor load
// restarts the count from zero.
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Tick when the count reaches the last cycle of the period.
    assign tick_o = (div_q != '0) && (cnt_q == div_q - 1'b1);

    // Divisor register and period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_we) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (div_q == '0 || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !div_we && div_q > 1) |=> !tick_o);  // R2
    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_we) && $past(div_in) == '0) |-> !tick_o);  // R2
endmodule

// File: rtl/uart_tx_fifo.sv
// Transmit holding store. It is a DEPTH-entry queue when fifo_en is 1 and
// a single entry when fifo_en is 0. A push into a full store is refused.
// Assumes fifo_en changes only while the store is empty.
module uart_tx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              accept,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [CW-1:0]     count_q;
    logic [CW-1:0]     limit;
    logic              full;

    // Capacity follows the buffering mode.
    assign limit  = fifo_en ? DEPTH_C : CW'(1);
    assign full   = count_q >= limit;
    assign accept = push_req && !full;
    assign empty  = (count_q == '0);
    assign head   = mem[rptr_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (accept) mem[wptr_q] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (accept) wptr_q <= (wptr_q == LAST_C) ? '0 : wptr_q + 1'b1;
            if (pop)    rptr_q <= (rptr_q == LAST_C) ? '0 : rptr_q + 1'b1;
            case ({accept, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);  // R7
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (count_q == $past(count_q)));  // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R12
endmodule

// File: rtl/uart_tx_shifter.sv
// Character shifter. It loads a prepared frame and sends one bit per 16 ticks,
// LSB first, then returns to idle. done_o marks the tick that ends the last bit.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame_in,
    output logic   busy_o,
    output logic   done_o,
    output logic   txd_o
);
    localparam int SW = $clog2(OVERSAMPLE);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVERSAMPLE - 1);

    logic [FRAME_W-1:0] sr_q;
    logic [LEN_W-1:0]   left_q;
    logic [SW-1:0]      sub_q;
    logic               busy_q;
    logic               bit_end;

    assign bit_end = busy_q && tick && (sub_q == SUB_LAST);
    assign done_o  = bit_end && (left_q == LEN_W'(1));
    assign busy_o  = busy_q;
    assign txd_o   = busy_q ? sr_q[0] : 1'b1;

    // Load a frame, count ticks within a bit, and shift at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '1;
            left_q <= '0;
            sub_q  <= '0;
            busy_q <= 1'b0;
        end else if (load && !busy_q) begin
            sr_q   <= frame_in.bits;
            left_q <= frame_in.len;
            sub_q  <= '0;
            busy_q <= 1'b1;
        end else if (bit_end) begin
            sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            sub_q  <= '0;
            if (left_q == LEN_W'(1)) busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            sub_q <= sub_q + 1'b1;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> txd_o);  // R4
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> !txd_o);  // R4
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick && !load) |=> $stable(txd_o));  // R3
endmodule

// File: rtl/uart_tx_core.sv
// Serial transmit path top. It joins the tick generator, the holding store
// and the shifter, and keeps the holding-empty and shifter-empty flags.
// Assumes fifo_en changes only while the store is empty.
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       thr_wr,
    input  logic [7:0] thr_data,
    input  logic       div_wr,
    input  logic [7:0] div_msb,
    input  logic [7:0] div_lsb,
    input  logic       fifo_en,
    input  logic       tx_int_en,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       parity_odd,
    input  logic       stop_two,
    output logic       txd,
    output logic       thr_empty,
    output logic       tsr_empty,
    output logic       tx_irq
);
    logic       tick;
    logic       accept, empty, busy, done, load;
    logic [7:0] head;
    line_cfg_t  cfg;
    frame_t     frame;
    logic       tsr_empty_q;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div_we(div_wr),
        .div_in(DIV_W'({div_msb, div_lsb})), .tick_o(tick)
    );

    uart_tx_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_req(thr_wr),
        .push_data(thr_data), .pop(load), .head(head), .accept(accept),
        .empty(empty)
    );

    // Frame assembly from the head byte and the current line settings.
    assign cfg   = '{wlen: word_len, par_en: parity_en, par_odd: parity_odd, two_stop: stop_two};
    assign frame = build_frame(head, cfg);
    assign load  = !busy && !empty;

    uart_tx_shifter #(.OVERSAMPLE(16)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .frame_in(frame),
        .busy_o(busy), .done_o(done), .txd_o(txd)
    );

    // Shifter-empty flag: a write clears it, a finished character with nothing queued sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)              tsr_empty_q <= 1'b1;
        else if (accept)         tsr_empty_q <= 1'b0;
        else if (done && empty)  tsr_empty_q <= 1'b1;
    end

    assign tsr_empty = tsr_empty_q;
    assign thr_empty = empty;
    assign tx_irq    = tx_int_en && empty;

    AST_WRITE_CLEARS_THR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !thr_empty);  // R9
    AST_WRITE_CLEARS_TSR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tsr_empty);  // R10
    AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tsr_empty);  // R10
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_int_en && thr_empty));  // R11
endmodule

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = '0;
    logic       div_wr = 1'b0;
    logic [7:0] div_msb = '0, div_lsb = '0;
    logic       fifo_en = 1'b0, tx_int_en = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0, parity_odd = 1'b0, stop_two = 1'b0;
    logic       txd, thr_empty, tsr_empty, tx_irq;

    uart_tx_core dut (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_data(thr_data),
        .div_wr(div_wr), .div_msb(div_msb), .div_lsb(div_lsb),
        .fifo_en(fifo_en), .tx_int_en(tx_int_en), .word_len(word_len),
        .parity_en(parity_en), .parity_odd(parity_odd), .stop_two(stop_two),
        .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty), .tx_irq(tx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int   m_div, m_cnt, m_sub;
    bit   m_busy, m_tsr, m_live;
    bit   m_bits[$];
    byte  m_q[$];
    int   vectors = 0, fails = 0, cycles = 0;
    string phase = "R1";

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_sub = 0; m_busy = 0; m_tsr = 1;
            m_bits.delete(); m_q.delete(); m_live = 1;
        end else begin
            bit tick, push, pop, fin;
            int old_len, lim;
            tick = (m_div != 0) && (m_cnt == m_div - 1);
            if (div_wr) begin m_div = {div_msb, div_lsb}; m_cnt = 0; end
            else if (m_div == 0 || tick) m_cnt = 0;
            else m_cnt++;
            old_len = m_q.size();
            lim  = fifo_en ? 16 : 1;
            push = thr_wr && (old_len < lim);
            pop  = !m_busy && old_len > 0;
            fin  = 0;
            if (m_busy && tick) begin
                if (m_sub == 15) begin
                    m_sub = 0;
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) begin m_busy = 0; fin = 1; end
                end else m_sub++;
            end
            if (pop) begin
                byte d; int nd; bit p;
                d = m_q.pop_front();
                nd = 5 + word_len;
                m_bits.delete();
                m_bits.push_back(1'b0);
                p = parity_odd;
                for (int i = 0; i < nd; i++) begin m_bits.push_back(d[i]); p ^= d[i]; end
                if (parity_en) m_bits.push_back(p);
                m_bits.push_back(1'b1);
                if (stop_two) m_bits.push_back(1'b1);
                m_busy = 1; m_sub = 0;
            end
            if (push) m_q.push_back(thr_data);
            if (push) m_tsr = 0;
            else if (fin && old_len == 0) m_tsr = 1;
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] at cycle %0d: actual %b expected %b", what, phase, cycles, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (m_live && rst_n) begin
            bit e_thr;
            e_thr = (m_q.size() == 0);
            chk("txd R4", txd, m_busy ? m_bits[0] : 1'b1);
            chk("thr_empty R9", thr_empty, e_thr);
            chk("tsr_empty R10", tsr_empty, m_tsr);
            chk("tx_irq R11", tx_irq, tx_int_en && e_thr);
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog [%s]: actual running expected done", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic write_byte(input byte b);
        @(negedge clk); #1; thr_wr = 1; thr_data = b;
        @(negedge clk); #1; thr_wr = 0;
    endtask

    task automatic set_div(input int d);
        @(negedge clk); #1; div_wr = 1; {div_msb, div_lsb} = 16'(d);
        @(negedge clk); #1; div_wr = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy || m_q.size() != 0 || !m_tsr);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        phase = "R1";
        chk("reset txd R1", txd, 1'b1);
        chk("reset thr_empty R1", thr_empty, 1'b1);
        chk("reset tsr_empty R1", tsr_empty, 1'b1);

        // R2 R4 R12: divisor 1, 8 data bits, no parity, single holding byte
        phase = "R2/R4/R12";
        tx_int_en = 1;
        set_div(1);
        write_byte(8'hA5);
        // R8: the first byte has moved on, so this one is held and the next is dropped
        phase = "R8";
        @(negedge clk); #1; thr_wr = 1; thr_data = 8'h3C;
        @(negedge clk); #1; thr_data = 8'hFF;
        @(negedge clk); #1; thr_wr = 0;
        wait_idle();

        // R3 R5 R6: short words, parity and two stop bits at a slower tick
        phase = "R3/R5/R6";
        set_div(3);
        for (int w = 0; w < 3; w++) begin
            word_len = 2'(w); parity_en = 1; parity_odd = w[0]; stop_two = 1;
            write_byte(8'h5A + 8'(w * 37));
            wait_idle();
        end
        word_len = 2'd3; parity_en = 1; parity_odd = 0; stop_two = 0;
        write_byte(8'h81);
        wait_idle();

        // R7: 16-deep buffering, overfill with 20 back-to-back writes
        phase = "R7";
        fifo_en = 1; parity_en = 0; set_div(1);
        @(negedge clk); #1; thr_wr = 1;
        for (int i = 0; i < 20; i++) begin
            thr_data = 8'(i * 13 + 1);
            @(negedge clk); #1;
        end
        thr_wr = 0;
        // R11: disable the interrupt while draining
        phase = "R11";
        repeat (200) @(negedge clk);
        #1 tx_int_en = 0;
        wait_idle();
        tx_int_en = 1;

        // R2: zero divisor stalls the start bit, reload restarts the count mid-bit
        phase = "R2";
        set_div(0);
        write_byte(8'hC3);
        repeat (100) @(negedge clk);
        set_div(2);
        repeat (7) @(negedge clk);
        set_div(2);
        wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule